// File: doc/BRIEF.md
# Command Buffer with Prefetch Pipe and Overflow Stall Queue

This block buffers command entries (an opcode and a parameter word) between a bus-side writer and a command executor. The executor reads from a small prefetch pipe. A larger main FIFO backs the pipe. A write goes straight into the pipe while the main FIFO is empty and the pipe has room. Otherwise it lands in the main FIFO. Whenever a read leaves the pipe nearly empty, a batch of entries moves up from the main FIFO.

When the main FIFO is full, further writes go into an overflow stall queue, and a stall output is raised towards the writing master. The stall queue is deep enough that a multi-word burst store can finish without being cut off. After each refill, stall-queue entries move back into the main FIFO until the queue empties or the main FIFO is full again. The stall output drops once the queue is empty.

Three status outputs are level-sensitive and are worked out every cycle from the current main FIFO level:
- a DMA request;
- an interrupt, whose condition is picked by a two-bit mode input;
- a busy flag, which tracks whether work is outstanding.

Top module: `cmd_fifo_prefetch`

## Requirements
- R1: An accepted write whose stall queue is empty after this cycle's drain goes into the prefetch pipe if the main FIFO is empty after this cycle's refill and drain and the pipe, after this cycle's read and refill, holds fewer than 4 entries; otherwise it goes into the main FIFO. `pipe_level` reports the pipe occupancy.
- R2: A write that finds the main FIFO full, or finds the stall queue already occupied, is placed in the stall queue, which holds 64 entries. `stall` is high exactly while the stall queue is occupied. `wr_ready` is low exactly while the stall queue holds 64 entries, and a write offered then is dropped.
- R3: A read (`rd_en` high while `rd_valid` is high) that leaves 2 or fewer entries in the pipe moves up to 2 of the oldest main FIFO entries into the pipe in the same cycle. `fifo_level` reports the main FIFO occupancy.
- R4: In a cycle with such a refill, stall-queue entries move, oldest first, into the main FIFO until the queue is empty or the main FIFO is full. `stall_level` reports the stall queue occupancy.
- R5: `rd_valid` is high while the pipe is occupied. `{rd_op, rd_arg}` shows the oldest buffered entry, so entries leave in exactly the order they were accepted. `rd_en` has no effect while the pipe is empty.
- R6: `irq_mode` selects the interrupt condition:
  - 1: `irq` is high while the main FIFO holds fewer than 128 entries;
  - 2: `irq` is high while the main FIFO is empty;
  - 0 or 3: `irq` is low.
- R7: `dma_req` is high while the main FIFO holds fewer than 128 entries.
- R8: `busy` is set by every accepted write. It is cleared in the cycle after `exec_done` is high while the pipe is empty and no write is accepted.
- R9: A synchronous reset empties the pipe, the main FIFO and the stall queue, and clears `busy` and `stall`. With the queues empty, `irq` and `dma_req` then follow R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Writer offers an entry |
| wr_ready | output | 1 | Entry will be accepted (stall queue not full) |
| wr_op | input | 8 | Opcode of offered entry |
| wr_arg | input | 32 | Parameter of offered entry |
| rd_en | input | 1 | Executor takes the head entry |
| rd_valid | output | 1 | Pipe holds at least one entry |
| rd_op | output | 8 | Opcode of head entry |
| rd_arg | output | 32 | Parameter of head entry |
| exec_done | input | 1 | Executor has finished its current work |
| irq_mode | input | 2 | Interrupt condition select |
| busy | output | 1 | Work outstanding |
| stall | output | 1 | Stall request to the writing master |
| dma_req | output | 1 | Main FIFO below half |
| irq | output | 1 | Interrupt, condition per `irq_mode` |
| pipe_level | output | 3 | Pipe occupancy |
| fifo_level | output | 9 | Main FIFO occupancy |
| stall_level | output | 7 | Stall queue occupancy |

## Verification
The assertions assume that reset is held high from time zero through the first clock edges. Their invariants rest on this: the stall queue is occupied only while the main FIFO is full, and the pipe is empty only while the main FIFO is empty. The assertions also assume nothing about `rd_en`, `wr_valid` or `exec_done`; in particular, `rd_en` may be high against an empty pipe.

The stimulus starts in reset and drives all inputs away from the clock edge. It does the following:
- overfills the buffer until `wr_ready` drops;
- drains it with reads alone;
- runs long random mixes of reads, writes, modes and completions;
- applies one mid-run reset.

Every output is compared each cycle against a queue-based model.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   // interrupt condition select encoding
   typedef enum logic [1:0] {
      IRQ_NONE  = 2'd0,
      IRQ_HALF  = 2'd1,
      IRQ_EMPTY = 2'd2,
      IRQ_NONE3 = 2'd3
   } irq_sel_e;
endpackage

// File: rtl/cmdq_ring.sv
// Ring buffer with several pushes and pops per cycle.
module cmdq_ring #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   parameter int NPUSH = 1,
   parameter int NPOP  = 1,
   localparam int AW   = $clog2(DEPTH),
   localparam int LW   = $clog2(DEPTH + 1),
   localparam int PCW  = $clog2(NPUSH + 1),
   localparam int QCW  = $clog2(NPOP + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PCW-1:0]    push_cnt,
   input  logic [NPUSH*W-1:0] push_data,
   input  logic [QCW-1:0]    pop_cnt,
   output logic [NPOP*W-1:0] peek,
   output logic [LW-1:0]     level
);
   if (DEPTH != (1 << AW)) begin : g_depth_chk
      $error("cmdq_ring: DEPTH must be a power of two");
   end
   if (NPUSH > DEPTH || NPOP > DEPTH) begin : g_port_chk
      $error("cmdq_ring: port count exceeds depth");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rptr, wptr;

   always_ff @(posedge clk) begin
      for (int i = 0; i < NPUSH; i++) begin
         if (i < int'(push_cnt))
            mem[wptr + AW'(i)] <= push_data[i*W +: W];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rptr  <= '0;
         wptr  <= '0;
         level <= '0;
      end else begin
         rptr  <= rptr + AW'(pop_cnt);
         wptr  <= wptr + AW'(push_cnt);
         level <= level + LW'(push_cnt) - LW'(pop_cnt);
      end
   end

   for (genvar g = 0; g < NPOP; g++) begin : g_peek
      assign peek[g*W +: W] = mem[rptr + AW'(g)];
   end
endmodule

// File: rtl/cmdq_ctrl.sv
// Per-cycle movement decisions: read, refill, drain, then write routing.
module cmdq_ctrl #(
   parameter int PIPE_DEPTH   = 4,
   parameter int MAIN_DEPTH   = 256,
   parameter int STALL_DEPTH  = 64,
   parameter int REFILL_MARK  = 2,
   parameter int REFILL_BATCH = 2,
   localparam int PLW = $clog2(PIPE_DEPTH + 1),
   localparam int MLW = $clog2(MAIN_DEPTH + 1),
   localparam int SLW = $clog2(STALL_DEPTH + 1),
   localparam int BW  = $clog2(REFILL_BATCH + 1)
) (
   input  logic [PLW-1:0] pipe_lvl,
   input  logic [MLW-1:0] main_lvl,
   input  logic [SLW-1:0] stall_lvl,
   input  logic           rd_en,
   input  logic           wr_valid,
   output logic           pop,
   output logic [BW-1:0]  refill_n,
   output logic [BW-1:0]  drain_n,
   output logic           to_pipe,
   output logic           to_main,
   output logic           to_stall,
   output logic           wr_ready
);
   int p, m, s, p1, r, m1, d, s1, m2;
   logic acc;

   always_comb begin
      p  = int'(pipe_lvl);
      m  = int'(main_lvl);
      s  = int'(stall_lvl);
      wr_ready = (s < STALL_DEPTH);
      pop = rd_en && (p != 0);
      p1 = pop ? p - 1 : p;
      r  = 0;
      if (pop && p1 <= REFILL_MARK)
         r = (m < REFILL_BATCH) ? m : REFILL_BATCH;
      m1 = m - r;
      d  = 0;
      if (r != 0) begin
         d = s;
         if (d > MAIN_DEPTH - m1) d = MAIN_DEPTH - m1;
         if (d > REFILL_BATCH)    d = REFILL_BATCH;
      end
      s1 = s - d;
      m2 = m1 + d;
      acc      = wr_valid && wr_ready;
      to_pipe  = acc && (s1 == 0) && (m2 == 0) && ((p1 + r) < PIPE_DEPTH);
      to_main  = acc && !to_pipe && (s1 == 0) && (m2 < MAIN_DEPTH);
      to_stall = acc && !to_pipe && !to_main;
      refill_n = BW'(r);
      drain_n  = BW'(d);
   end
endmodule

// File: rtl/cmd_fifo_prefetch.sv
module cmd_fifo_prefetch #(
   parameter int PIPE_DEPTH   = 4,
   parameter int MAIN_DEPTH   = 256,
   parameter int STALL_DEPTH  = 64,
   parameter int REFILL_MARK  = 2,
   parameter int REFILL_BATCH = 2,
   parameter int OP_W         = 8,
   parameter int ARG_W        = 32,
   localparam int W    = OP_W + ARG_W,
   localparam int PLW  = $clog2(PIPE_DEPTH + 1),
   localparam int MLW  = $clog2(MAIN_DEPTH + 1),
   localparam int SLW  = $clog2(STALL_DEPTH + 1),
   localparam int BW   = $clog2(REFILL_BATCH + 1),
   localparam int PPW  = $clog2(REFILL_BATCH + 2),
   localparam int HALF = MAIN_DEPTH / 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [OP_W-1:0]  wr_op,
   input  logic [ARG_W-1:0] wr_arg,
   input  logic             rd_en,
   output logic             rd_valid,
   output logic [OP_W-1:0]  rd_op,
   output logic [ARG_W-1:0] rd_arg,
   input  logic             exec_done,
   input  logic [1:0]       irq_mode,
   output logic             busy,
   output logic             stall,
   output logic             dma_req,
   output logic             irq,
   output logic [PLW-1:0]   pipe_level,
   output logic [MLW-1:0]   fifo_level,
   output logic [SLW-1:0]   stall_level
);
   import cmdq_pkg::*;

   if (PIPE_DEPTH < REFILL_MARK + REFILL_BATCH) begin : g_pipe_chk
      $error("cmd_fifo_prefetch: pipe too shallow for refill batch");
   end
   if (STALL_DEPTH < 1 || MAIN_DEPTH < 2) begin : g_depth_chk
      $error("cmd_fifo_prefetch: depths too small");
   end

   logic [W-1:0] wr_ent;
   assign wr_ent = {wr_op, wr_arg};

   logic          pop, to_pipe, to_main, to_stall;
   logic [BW-1:0] refill_n, drain_n;

   cmdq_ctrl #(
      .PIPE_DEPTH(PIPE_DEPTH), .MAIN_DEPTH(MAIN_DEPTH), .STALL_DEPTH(STALL_DEPTH),
      .REFILL_MARK(REFILL_MARK), .REFILL_BATCH(REFILL_BATCH)
   ) u_ctrl (
      .pipe_lvl(pipe_level), .main_lvl(fifo_level), .stall_lvl(stall_level),
      .rd_en(rd_en), .wr_valid(wr_valid), .pop(pop),
      .refill_n(refill_n), .drain_n(drain_n),
      .to_pipe(to_pipe), .to_main(to_main), .to_stall(to_stall),
      .wr_ready(wr_ready)
   );

   logic [(REFILL_BATCH+1)*W-1:0] pipe_push;
   logic [REFILL_BATCH*W-1:0]     main_push, main_peek, stall_peek;
   logic [W-1:0]                  pipe_head;
   logic [PPW-1:0]                pipe_push_cnt;
   logic [BW-1:0]                 main_push_cnt;

   // refill entries first, then a bypassing write
   for (genvar k = 0; k <= REFILL_BATCH; k++) begin : g_pipe_in
      if (k < REFILL_BATCH) begin : g_mix
         assign pipe_push[k*W +: W] = (k < int'(refill_n)) ? main_peek[k*W +: W] : wr_ent;
      end else begin : g_last
         assign pipe_push[k*W +: W] = wr_ent;
      end
   end
   // drained stall entries first, then a new write
   for (genvar k = 0; k < REFILL_BATCH; k++) begin : g_main_in
      assign main_push[k*W +: W] = (k < int'(drain_n)) ? stall_peek[k*W +: W] : wr_ent;
   end

   assign pipe_push_cnt = PPW'(refill_n) + PPW'(to_pipe);
   assign main_push_cnt = drain_n + BW'(to_main);

   cmdq_ring #(.DEPTH(PIPE_DEPTH), .W(W), .NPUSH(REFILL_BATCH + 1), .NPOP(1)) u_pipe (
      .clk(clk), .rst(rst), .push_cnt(pipe_push_cnt), .push_data(pipe_push),
      .pop_cnt(pop), .peek(pipe_head), .level(pipe_level)
   );

   cmdq_ring #(.DEPTH(MAIN_DEPTH), .W(W), .NPUSH(REFILL_BATCH), .NPOP(REFILL_BATCH)) u_main (
      .clk(clk), .rst(rst), .push_cnt(main_push_cnt), .push_data(main_push),
      .pop_cnt(refill_n), .peek(main_peek), .level(fifo_level)
   );

   cmdq_ring #(.DEPTH(STALL_DEPTH), .W(W), .NPUSH(1), .NPOP(REFILL_BATCH)) u_stallq (
      .clk(clk), .rst(rst), .push_cnt(to_stall), .push_data(wr_ent),
      .pop_cnt(drain_n), .peek(stall_peek), .level(stall_level)
   );

   assign rd_valid        = (pipe_level != '0);
   assign {rd_op, rd_arg} = pipe_head;
   assign stall           = (stall_level != '0);
   assign dma_req         = (fifo_level < MLW'(HALF));

   always_comb begin
      case (irq_sel_e'(irq_mode))
         IRQ_HALF:  irq = (fifo_level < MLW'(HALF));
         IRQ_EMPTY: irq = (fifo_level == '0);
         default:   irq = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)                                busy <= 1'b0;
      else if (wr_valid && wr_ready)          busy <= 1'b1;
      else if (exec_done && pipe_level == '0) busy <= 1'b0;
   end
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
   parameter int PIPE_DEPTH  = 4,
   parameter int MAIN_DEPTH  = 256,
   parameter int STALL_DEPTH = 64,
   localparam int PLW = $clog2(PIPE_DEPTH + 1),
   localparam int MLW = $clog2(MAIN_DEPTH + 1),
   localparam int SLW = $clog2(STALL_DEPTH + 1)
) (
   input logic           clk,
   input logic           rst,
   input logic           wr_valid,
   input logic           wr_ready,
   input logic           rd_en,
   input logic           exec_done,
   input logic [1:0]     irq_mode,
   input logic           busy,
   input logic           stall,
   input logic           dma_req,
   input logic           irq,
   input logic [PLW-1:0] pipe_level,
   input logic [MLW-1:0] fifo_level,
   input logic [SLW-1:0] stall_level
);
   assert_reset_clears_R9: assert property (@(posedge clk)
      rst |=> (pipe_level == '0 && fifo_level == '0 && stall_level == '0 && !busy && !stall));

   assert_stall_needs_full_R2: assert property (@(posedge clk) disable iff (rst)
      (stall_level != '0) |-> (fifo_level == MLW'(MAIN_DEPTH)));

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
      stall_level <= SLW'(STALL_DEPTH));

   assert_pipe_fed_R3: assert property (@(posedge clk) disable iff (rst)
      (fifo_level != '0) |-> (pipe_level != '0));

   assert_drain_on_read_R4: assert property (@(posedge clk) disable iff (rst)
      (stall_level < $past(stall_level) && !$past(rst)) |-> $past(rd_en));

   assert_empty_irq_has_dma_R6: assert property (@(posedge clk) disable iff (rst)
      (irq_mode == 2'd2 && irq) |-> dma_req);

   assert_busy_on_write_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready) |=> busy);

   assert_busy_clear_R8: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |-> ($past(exec_done) && $past(pipe_level) == '0));
endmodule

bind cmd_fifo_prefetch cmdq_checker #(
   .PIPE_DEPTH(PIPE_DEPTH), .MAIN_DEPTH(MAIN_DEPTH), .STALL_DEPTH(STALL_DEPTH)
) u_chk (
   .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_en(rd_en),
   .exec_done(exec_done), .irq_mode(irq_mode), .busy(busy), .stall(stall),
   .dma_req(dma_req), .irq(irq), .pipe_level(pipe_level), .fifo_level(fifo_level),
   .stall_level(stall_level)
);

// File: tb/sim_cmd_fifo_prefetch.sv
`timescale 1ns/1ps
module sim_cmd_fifo_prefetch;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_valid = 1'b0, rd_en = 1'b0, exec_done = 1'b0;
   logic [7:0]  wr_op = '0;
   logic [31:0] wr_arg = '0;
   logic [1:0]  irq_mode = 2'd0;
   logic        wr_ready, rd_valid, busy, stall, dma_req, irq;
   logic [7:0]  rd_op;
   logic [31:0] rd_arg;
   logic [2:0]  pipe_level;
   logic [8:0]  fifo_level;
   logic [6:0]  stall_level;

   always #2.5 clk = ~clk;

   cmd_fifo_prefetch u0 (
      .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_op(wr_op), .wr_arg(wr_arg), .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_op(rd_op), .rd_arg(rd_arg), .exec_done(exec_done), .irq_mode(irq_mode),
      .busy(busy), .stall(stall), .dma_req(dma_req), .irq(irq),
      .pipe_level(pipe_level), .fifo_level(fifo_level), .stall_level(stall_level)
   );

   // reference model
   logic [39:0] pq[$];
   logic [39:0] mq[$];
   logic [39:0] sq[$];
   bit          mbusy = 1'b0;
   int          n_tests = 0, n_fail = 0;
   bit          done = 1'b0;
   int unsigned seq = 0;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic route(input logic [39:0] e);
      if (mq.size() == 0 && pq.size() < 4) pq.push_back(e);
      else if (mq.size() < 256)            mq.push_back(e);
      else                                 sq.push_back(e);
   endtask

   task automatic model_step();
      int  p0, s0;
      bit  acc;
      logic [39:0] e;
      if (rst) begin
         pq.delete(); mq.delete(); sq.delete(); mbusy = 1'b0;
         return;
      end
      p0  = pq.size();
      s0  = sq.size();
      acc = wr_valid && (s0 < 64);
      e   = {wr_op, wr_arg};
      if (rd_en && p0 > 0) begin
         void'(pq.pop_front());
         if (pq.size() <= 2) begin
            for (int k = 0; k < 2; k++)
               if (mq.size() > 0) pq.push_back(mq.pop_front());
            while (sq.size() > 0 && mq.size() < 256) route(sq.pop_front());
         end
      end
      if (acc) begin
         if (sq.size() > 0) sq.push_back(e);
         else route(e);
      end
      if (acc) mbusy = 1'b1;
      else if (exec_done && p0 == 0) mbusy = 1'b0;
   endtask

   task automatic compare_all();
      int m;
      m = mq.size();
      chk("R1", "pipe_level", pipe_level, pq.size());
      chk("R3", "fifo_level", fifo_level, m);
      chk("R4", "stall_level", stall_level, sq.size());
      chk("R5", "rd_valid", rd_valid, pq.size() > 0);
      if (pq.size() > 0) chk("R5", "head entry", {rd_op, rd_arg}, pq[0]);
      chk("R2", "stall", stall, sq.size() > 0);
      chk("R2", "wr_ready", wr_ready, sq.size() < 64);
      chk("R7", "dma_req", dma_req, m < 128);
      chk("R6", "irq", irq, (irq_mode == 2'd1) ? (m < 128) : (irq_mode == 2'd2) ? (m == 0) : 0);
      chk("R8", "busy", busy, mbusy);
   endtask

   task automatic step(input bit r, input bit wv, input bit re, input bit ed, input logic [1:0] md);
      @(negedge clk);
      rst = r; wr_valid = wv; rd_en = re; exec_done = ed; irq_mode = md;
      seq++;
      wr_arg = seq; wr_op = seq[7:0] ^ 8'h5A;
      #1 compare_all();
      @(posedge clk);
      model_step();
   endtask

   initial begin
      // R9: reset state
      for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 2'd1);
      @(negedge clk);
      chk("R9", "reset pipe_level", pipe_level, 0);
      chk("R9", "reset fifo_level", fifo_level, 0);
      chk("R9", "reset stall_level", stall_level, 0);
      chk("R9", "reset busy", busy, 0);
      chk("R9", "reset stall", stall, 0);
      // R1/R2: overfill without reads until the stall queue is full
      for (int i = 0; i < 300; i++) step(0, 1, 0, 0, 2'd1);
      for (int i = 0; i < 40; i++) step(0, 1, 0, 0, 2'd2);
      @(negedge clk);
      chk("R2", "stall queue full", stall_level, 64);
      chk("R2", "ready low when full", wr_ready, 0);
      // R3/R4: drain with reads only
      for (int i = 0; i < 400; i++) step(0, 0, 1, $urandom_range(1, 0), (i % 2) ? 2'd1 : 2'd2);
      // random mixes
      for (int i = 0; i < 1500; i++) begin
         int wp;
         wp = (i < 700) ? 70 : 35;
         step(0, $urandom_range(99, 0) < wp, $urandom_range(99, 0) < 50,
              $urandom_range(99, 0) < 30, 2'($urandom_range(3, 0)));
      end
      // R9: mid-run reset
      step(1, 1, 1, 0, 2'd0);
      for (int i = 0; i < 300; i++)
         step(0, $urandom_range(99, 0) < 60, $urandom_range(99, 0) < 40, 1'b0, 2'($urandom_range(3, 0)));
      // R8: final drain with completions, busy must clear
      for (int i = 0; i < 400; i++) step(0, 0, 1, 1, 2'd2);
      @(negedge clk);
      chk("R8", "busy cleared after drain", busy, 0);
      chk("R6", "empty-mode irq after drain", irq, 1);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule